// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for each frame, whether to keep or discard it based on the destination address. That address is carried in the first six bytes of the frame. Software programs two exact-match station addresses, a 64-entry group hash table and a small control word through a simple write port. The filter captures the address bytes as they arrive, compares them against the enabled station slots and the broadcast address, and looks up a 6-bit XOR-fold of the address in the hash table. The hash table behaves as a one-hash Bloom filter for group addresses.

The block produces one verdict per frame as a single-cycle `vrd_valid` pulse together with `vrd_accept`. The pulse comes one cycle after the twelfth byte, or one cycle after the last byte of a frame that ends sooner; such a short frame is always dropped. `vrd_accept` keeps its value until the next start of frame. Every frame is judged against a copy of the configuration taken at its first byte. A register write that arrives while a frame is in flight therefore affects only later frames.

Top module: `rx_dest_filter`

## Requirements
- R1: When control bit 0 is set, a frame whose destination equals station slot 0 is accepted. Slot 0 low word (offset 1) holds address bytes 0..3 with byte 0 in bits 7:0. Slot 0 high word (offset 2) holds bytes 4 and 5 in bits 15:0. Byte 0 is the first byte received.
- R2: When control bit 1 is set, a frame whose destination equals station slot 1 is accepted (low word at offset 3, high word at offset 4, same byte layout as R1).
- R3: When control bit 3 is set, a frame whose destination is all ones is accepted.
- R4: The hash index is the XOR of the eight 6-bit slices of the 48-bit address. Address bit i is bit (i mod 8) of byte (i div 8), and slice k covers bits 6k..6k+5. Indices 0..31 select a bit of the group low word (offset 5). Indices 32..63 select bit (index-32) of the group high word (offset 6). A set bit is a hit.
- R5: The hash table is consulted only when bit 0 of address byte 0 is set, unless control bit 2 is set, which lets individual addresses hash as well.
- R6: A frame that ends (last-byte flag) before its twelfth byte is dropped. Its verdict pulse appears in the cycle after that last byte.
- R7: For a frame of twelve or more bytes, the verdict pulse appears in the cycle after the twelfth byte. Exactly one pulse is produced per frame, and a later end of frame produces none. A new start-of-frame byte abandons any frame in progress.
- R8: `vrd_accept` holds its value between verdicts. It reads 0 from the cycle after a start-of-frame byte until that frame's verdict, and both outputs are 0 after reset.
- R9: Each frame uses the configuration as it stood before its start-of-frame byte. Writes during a frame, including one in the same cycle as the start-of-frame byte, apply from the next frame on.
- R10: The control word is at offset 0, and only bits 3:0 of it are stored. A write to offset 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| vrd_valid | output | 1 | One-cycle verdict strobe |
| vrd_accept | output | 1 | Verdict: 1 keep, 0 discard; held until next frame start |

## Verification
On every cycle, assertions check the following:
- broadcast and slot-0 matches always produce a hit under their enables;
- an individual address with no exact or broadcast match never hits while individual hashing is off;
- the configuration snapshot moves only on a start-of-frame byte, and writes to the spare offset leave the configuration untouched;
- no second verdict fires within a frame;
- the held verdict changes only at a strobe or a frame start.

Only the bench's scenarios can show the exact verdict cycle and the correct hash index, including which table half is used. The same holds for the byte ordering of the station words, the dropping of short frames, and the one-frame delay of a mid-frame write. These are shown by comparing against a behavioural model on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int ADDR_BITS  = ADDR_BYTES * 8;
    localparam int NUM_SLOTS  = 2;
    localparam int HASH_BITS  = 6;
    localparam int TBL_SIZE   = 1 << HASH_BITS;
    localparam int NUM_SLICES = ADDR_BITS / HASH_BITS;
    localparam int CTRL_W     = 4;
    localparam int CFG_AW     = 3;
    localparam int CFG_DW     = 32;

    // control bit positions (slot enables occupy bits 0..NUM_SLOTS-1)
    localparam int CB_HASH_IND = 2;
    localparam int CB_BCAST    = 3;

    // word offsets
    localparam logic [CFG_AW-1:0] OFF_CTRL   = 3'd0;
    localparam logic [CFG_AW-1:0] OFF_SLOT   = 3'd1;
    localparam logic [CFG_AW-1:0] OFF_GRP_LO = 3'd5;
    localparam logic [CFG_AW-1:0] OFF_GRP_HI = 3'd6;

    typedef struct packed {
        logic [CTRL_W-1:0]                   ctrl;
        logic [NUM_SLOTS-1:0][ADDR_BITS-1:0] slot;
        logic [TBL_SIZE-1:0]                 grp;
    } cfg_t;

    function automatic logic [HASH_BITS-1:0] fold_hash(input logic [ADDR_BITS-1:0] a);
        logic [HASH_BITS-1:0] h;
        h = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            h = h ^ a[s*HASH_BITS +: HASH_BITS];
        end
        return h;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    output cfg_t              snap
);

    typedef struct packed {
        cfg_t shadow;
        cfg_t snap;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (frame_start) begin
            regs_d.snap = regs_q.shadow;
        end
        if (cfg_we) begin
            if (cfg_addr == OFF_CTRL) begin
                regs_d.shadow.ctrl = cfg_wdata[CTRL_W-1:0];
            end
            if (cfg_addr == OFF_GRP_LO) begin
                regs_d.shadow.grp[TBL_SIZE/2-1:0] = cfg_wdata;
            end
            if (cfg_addr == OFF_GRP_HI) begin
                regs_d.shadow.grp[TBL_SIZE-1:TBL_SIZE/2] = cfg_wdata;
            end
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (cfg_addr == OFF_SLOT + CFG_AW'(2*k)) begin
                    regs_d.shadow.slot[k][31:0] = cfg_wdata;
                end
                if (cfg_addr == OFF_SLOT + CFG_AW'(2*k+1)) begin
                    regs_d.shadow.slot[k][ADDR_BITS-1:32] = cfg_wdata[ADDR_BITS-33:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign snap = regs_q.snap;

    // R9: the per-frame copy only moves on a start-of-frame byte
    a_r9_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(regs_q.snap));

    // R10: the spare offset has no effect on the stored configuration
    a_r10_spare_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd7) |=> $stable(regs_q.shadow));

endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
    import rxf_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_data,
    output logic [ADDR_BITS-1:0] da,
    output logic                 fire,
    output logic                 len_ok
);

    localparam int CNT_W = $clog2(MIN_LEN + 1);

    typedef struct packed {
        logic                 open;
        logic                 done;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_BITS-1:0] da;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d  = cap_q;
        fire   = 1'b0;
        len_ok = 1'b0;
        if (rx_valid) begin
            if (rx_sof) begin
                cap_d.open     = !rx_eof;
                cap_d.done     = rx_eof;
                cap_d.cnt      = CNT_W'(1);
                cap_d.da[7:0]  = rx_data;
                fire           = rx_eof;
            end else if (cap_q.open) begin
                if (!cap_q.done) begin
                    cap_d.cnt = cap_q.cnt + 1'b1;
                    for (int b = 1; b < ADDR_BYTES; b++) begin
                        if (cap_q.cnt == CNT_W'(b)) begin
                            cap_d.da[b*8 +: 8] = rx_data;
                        end
                    end
                    if (cap_q.cnt == CNT_W'(MIN_LEN - 1)) begin
                        fire       = 1'b1;
                        len_ok     = 1'b1;
                        cap_d.done = 1'b1;
                    end else if (rx_eof) begin
                        fire       = 1'b1;
                        cap_d.done = 1'b1;
                    end
                end
                if (rx_eof) begin
                    cap_d.open = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign da = cap_q.da;

    // R7: once judged, a frame produces no further verdict
    a_r7_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.done && !(rx_valid && rx_sof)) |-> !fire);

    // R6: a verdict without full length can only come from a last byte
    a_r6_short_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !len_ok) |-> (rx_valid && rx_eof));

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
(
    input  cfg_t                 cfg,
    input  logic [ADDR_BITS-1:0] da,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output logic                 bcast_hit,
    output logic                 hash_hit,
    output logic                 hit
);

    logic [HASH_BITS-1:0] idx;
    logic                 hash_allowed;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_hit[k] = cfg.ctrl[k] && (da == cfg.slot[k]);
    end

    always_comb begin
        idx          = fold_hash(da);
        hash_allowed = da[0] || cfg.ctrl[CB_HASH_IND];
        hash_hit     = hash_allowed && cfg.grp[idx];
        bcast_hit    = cfg.ctrl[CB_BCAST] && (&da);
        hit          = (|slot_hit) || bcast_hit || hash_hit;
    end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              vrd_valid,
    output logic              vrd_accept
);

    typedef struct packed {
        logic valid;
        logic accept;
    } vrd_t;

    logic                 frame_start;
    cfg_t                 snap;
    logic [ADDR_BITS-1:0] da;
    logic                 fire;
    logic                 len_ok;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 bcast_hit;
    logic                 hash_hit;
    logic                 hit;
    vrd_t                 vrd_d, vrd_q;

    assign frame_start = rx_valid && rx_sof;

    rxf_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .snap        (snap)
    );

    rxf_da_capture #(.MIN_LEN(MIN_LEN)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_data  (rx_data),
        .da       (da),
        .fire     (fire),
        .len_ok   (len_ok)
    );

    rxf_addr_match u_match (
        .cfg       (snap),
        .da        (da),
        .slot_hit  (slot_hit),
        .bcast_hit (bcast_hit),
        .hash_hit  (hash_hit),
        .hit       (hit)
    );

    always_comb begin
        vrd_d       = vrd_q;
        vrd_d.valid = fire;
        if (frame_start) begin
            vrd_d.accept = 1'b0;
        end
        if (fire) begin
            vrd_d.accept = len_ok && hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vrd_q <= '0;
        end else begin
            vrd_q <= vrd_d;
        end
    end

    assign vrd_valid  = vrd_q.valid;
    assign vrd_accept = vrd_q.accept;

    // R8: held verdict only moves at a strobe or a frame start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !frame_start) |=> $stable(vrd_accept));

    // R8: a frame start clears the held verdict
    a_r8_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !vrd_accept);

    // R3: enabled broadcast always matches the all-ones address
    a_r3_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (snap.ctrl[CB_BCAST] && (&da)) |-> hit);

    // R1: enabled slot 0 always matches its own address
    a_r1_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (snap.ctrl[0] && da == snap.slot[0]) |-> slot_hit[0]);

    // R5: individual addresses never hash while individual hashing is off
    a_r5_no_ind_hash: assert property (@(posedge clk) disable iff (!rst_n)
        (!da[0] && !snap.ctrl[CB_HASH_IND]) |-> !hash_hit);

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        vrd_valid;
    logic        vrd_accept;

    always #4 clk = ~clk;

    rx_dest_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .vrd_valid  (vrd_valid),
        .vrd_accept (vrd_accept)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R8";
    bit    finished = 1'b0;

    // behavioural reference model
    bit [31:0] m_reg [8];
    bit [31:0] m_snap [8];
    bit        m_open, m_done;
    int        m_cnt;
    bit [7:0]  m_da [6];
    bit        exp_v, exp_a;

    function automatic int model_hash(bit [7:0] a [6]);
        int h = 0;
        for (int i = 0; i < 48; i++) begin
            if (a[i/8][i%8]) h = h ^ (1 << (i % 6));
        end
        return h;
    endfunction

    function automatic bit model_match();
        bit [47:0] d = '0;
        bit [47:0] s0, s1;
        int h;
        bit hash_on;
        for (int b = 0; b < 6; b++) d[b*8 +: 8] = m_da[b];
        s0 = {m_snap[2][15:0], m_snap[1]};
        s1 = {m_snap[4][15:0], m_snap[3]};
        h = model_hash(m_da);
        hash_on = m_da[0][0] || m_snap[0][2];
        if (m_snap[0][0] && d == s0) return 1'b1;
        if (m_snap[0][1] && d == s1) return 1'b1;
        if (m_snap[0][3] && d == '1) return 1'b1;
        if (hash_on && (h < 32 ? m_snap[5][h] : m_snap[6][h-32])) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_reg[i]) begin m_reg[i] = '0; m_snap[i] = '0; end
            m_open = 0; m_done = 0; m_cnt = 0;
            exp_v = 0; exp_a = 0;
        end else begin
            exp_v = 0;
            if (rx_valid && rx_sof) begin
                m_snap = m_reg;
                m_open = !rx_eof; m_done = rx_eof; m_cnt = 1;
                m_da[0] = rx_data;
                exp_a = 0;
                if (rx_eof) exp_v = 1;
            end else if (rx_valid && m_open) begin
                if (!m_done) begin
                    m_cnt++;
                    if (m_cnt <= 6) m_da[m_cnt-1] = rx_data;
                    if (m_cnt == 12) begin
                        exp_v = 1; exp_a = model_match(); m_done = 1;
                    end else if (rx_eof) begin
                        exp_v = 1; exp_a = 0; m_done = 1;
                    end
                end
                if (rx_eof) m_open = 0;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_reg[0] = cfg_wdata & 32'hF;
                    3'd2, 3'd4: m_reg[cfg_addr] = cfg_wdata & 32'hFFFF;
                    3'd7: ;
                    default: m_reg[cfg_addr] = cfg_wdata;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (vrd_valid !== exp_v || vrd_accept !== exp_a) begin
                n_bad++;
                $display("FAIL %s t=%0t valid/accept actual=%b%b expected=%b%b",
                         cur_req, $time, vrd_valid, vrd_accept, exp_v, exp_a);
            end
        end
    end

    // stimulus helpers (all driven right after a falling edge)
    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        repeat (n) @(negedge clk);
    endtask

    // len bytes; destination from dst; optional cfg write at byte wi; gap inserts idle cycles
    task automatic send(input bit [7:0] dst [6], input int len, input bit gap,
                        input int wi, input bit [2:0] wa, input bit [31:0] wd);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = (i < 6) ? dst[i] : 8'(i * 7 + 3);
            if (i == wi) begin cfg_we = 1; cfg_addr = wa; cfg_wdata = wd; end
            @(negedge clk);
            cfg_we = 0;
            if (gap && (i % 3 == 1)) idle(1);
        end
        idle(3);
    endtask

    task automatic frame(input bit [7:0] dst [6], input int len);
        send(dst, len, 1'b0, -1, 3'd0, 32'd0);
    endtask

    bit [7:0] a0 [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    bit [7:0] a1 [6] = '{8'h0A, 8'hB0, 8'hC1, 8'hD2, 8'hE3, 8'hF4};
    bit [7:0] bc [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    bit [7:0] mc [6] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h00};
    bit [7:0] uc [6] = '{8'h00, 8'h21, 8'h43, 8'h65, 8'h87, 8'hA9};
    bit [7:0] mlo [6];
    bit [7:0] mhi [6];

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int h;
        idle(4);
        @(negedge clk);
        rst_n = 1;
        // R8: reset state
        n_cmp++;
        if (vrd_valid !== 0 || vrd_accept !== 0) begin
            n_bad++;
            $display("FAIL R8 reset actual=%b%b expected=00", vrd_valid, vrd_accept);
        end

        // R1: slot 0 byte layout
        cur_req = "R1";
        wr(3'd1, 32'h33221102); wr(3'd2, 32'hABCD5544);
        wr(3'd3, 32'hD2C1B00A); wr(3'd4, 32'h0000F4E3);
        frame(a0, 16);
        wr(3'd0, 32'h1);
        frame(a0, 16);
        send(a0, 20, 1'b1, -1, 3'd0, 32'd0);
        frame(a1, 14);
        // R2: slot 1
        cur_req = "R2";
        wr(3'd0, 32'h2);
        frame(a1, 12);
        frame(a0, 12);
        // R3: broadcast
        cur_req = "R3";
        frame(bc, 13);
        wr(3'd0, 32'h8);
        frame(bc, 13);

        // R4: hash lookup in both halves
        cur_req = "R4";
        mlo = mc; mhi = mc;
        for (int v = 0; v < 256; v++) begin
            mc[5] = 8'(v);
            h = model_hash(mc);
            if (h < 32) mlo = mc; else mhi = mc;
        end
        wr(3'd0, 32'h0);
        frame(mlo, 12); frame(mhi, 12);
        h = model_hash(mlo); wr(3'd5, 32'(1) << h);
        frame(mlo, 12); frame(mhi, 12);
        h = model_hash(mhi); wr(3'd6, 32'(1) << (h - 32));
        frame(mhi, 12);
        wr(3'd5, 32'h0);
        frame(mlo, 12);

        // R5: individual addresses and the hash table
        cur_req = "R5";
        wr(3'd5, 32'hFFFFFFFF); wr(3'd6, 32'hFFFFFFFF);
        frame(uc, 12);
        wr(3'd0, 32'h4);
        frame(uc, 12);
        wr(3'd5, 32'h0); wr(3'd6, 32'h0); wr(3'd0, 32'h1);

        // R6: short frames
        cur_req = "R6";
        frame(a0, 11);
        frame(a0, 1);
        send(a0, 6, 1'b1, -1, 3'd0, 32'd0);

        // R7: restart mid-frame, one verdict, long frame
        cur_req = "R7";
        send(a1, 5, 1'b0, -1, 3'd0, 32'd0);
        frame(a0, 30);
        rx_valid = 1; rx_sof = 1; rx_eof = 0; rx_data = 8'h02;
        @(negedge clk);
        frame(a0, 12);

        // R8: hold over idle, clear on frame start
        cur_req = "R8";
        frame(a0, 12);
        idle(10);
        frame(bc, 12);

        // R9: writes during a frame apply next frame
        cur_req = "R9";
        send(a0, 14, 1'b0, 5, 3'd0, 32'h0);
        frame(a0, 14);
        send(a0, 14, 1'b0, 0, 3'd0, 32'h1);
        frame(a0, 14);
        send(a0, 14, 1'b1, 8, 3'd1, 32'h0);
        frame(a0, 14);

        // R10: spare offset and control width
        cur_req = "R10";
        wr(3'd1, 32'h33221102);
        wr(3'd7, 32'hFFFFFFFF);
        frame(bc, 12);
        frame(a0, 12);
        wr(3'd0, 32'hFFFFFFF0);
        frame(bc, 12);
        frame(uc, 12);

        idle(5);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule